// File: doc/BRIEF.md
# Chroma 2x2 Averaging Downsampler

This block reduces one square chroma plane of 8-bit samples to a quarter-size block. Each output sample averages a 2x2 neighbourhood of the input, so the reduction is 2:1 both across and down. With the default size, a 16x16 plane becomes an 8x8 block. The plane arrives over a valid/ready stream and is kept in a local buffer. Processing begins only after the whole plane is stored. The 64 results then leave over a second valid/ready stream in raster order. The first result carries a start-of-block flag and the last carries an end-of-block flag.

A single instance is shared between the two chroma components. The system sends the blue-difference plane, collects its block, and then sends the red-difference plane. A one-bit component tag, given with the first sample of each plane, comes back with every output sample of that plane's block, so the stage downstream can pick the right tables. The block handles one plane at a time. While it drains a block, its input is closed.

Back-pressure rules: an input sample is taken on a cycle where `in_valid` and `in_ready` are both high. An output sample is consumed on a cycle where `out_valid` and `out_ready` are both high. `out_valid` does not depend on `out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value. The sender may raise `in_valid` at any time. Data offered while `in_ready` is low is ignored.

Top module: `chroma_pool2x2`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Input samples are taken in raster order, one per input handshake. The n-th accepted sample of a plane (n = 0..255) is the sample at row n/16, column n%16.
- R3: `in_ready` goes low in the cycle after the 256th input handshake of a plane. It stays low until the cycle after the 64th output handshake. Values offered on `in_valid`, `in_data` and `in_comp` while it is low have no effect on any output.
- R4: `out_valid` rises in the cycle after the 256th input handshake. It stays high until the 64th output handshake.
- R5: Output k (row r = k/8, column c = k%8) equals (s[2r][2c] + s[2r][2c+1] + s[2r+1][2c] + s[2r+1][2c+1] + 2) >> 2. The result is rounded half up and never exceeds 255.
- R6: Outputs leave in raster order, k = 0..63, one per output handshake. With `out_ready` held high, the 64 samples appear on 64 consecutive cycles.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_comp`, `out_sob` and `out_eob` keep their values into the next cycle.
- R8: `out_sob` is 1 only with output k = 0, and `out_eob` is 1 only with output k = 63. Both are 0 whenever `out_valid` is 0.
- R9: `in_comp` is sampled only on the first input handshake of a plane (0 = blue difference, 1 = red difference). `out_comp` presents that value with all 64 outputs of the plane's block. `in_comp` on the other 255 handshakes is ignored.
- R10: Planes are processed back to back with no limit. After each block's last output handshake, the next plane fills and drains with the same timing and results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block accepts an input sample |
| in_data | input | 8 | Input chroma sample, raster order |
| in_comp | input | 1 | Component tag, sampled with the first sample of a plane |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Receiver accepts the output sample |
| out_data | output | 8 | Averaged output sample |
| out_comp | output | 1 | Component tag of the current block |
| out_sob | output | 1 | First sample of the block |
| out_eob | output | 1 | Last sample of the block |

## Verification
Three situations are hard to reach from the ports. The first is a sender that keeps offering data, with a deliberately wrong tag, during the whole drain phase. The second is the exact cycle where the last output handshake reopens the input. The third is a tag that changes after the first sample of a plane. The stimulus holds `in_valid` high with random data and an inverted tag whenever `in_ready` is low. On one plane it toggles `in_comp` on every sample. It runs the output side with always-ready, half-ready and sparse-ready patterns, so back-pressure lands on the start and end samples. To show that rounding goes up rather than truncating, one plane uses neighbourhoods whose sum leaves a remainder of 2. Further planes use all-255 and all-zero data for the range limits.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_t;

  localparam int TAPS = 4;
endpackage

// File: rtl/plane_store.sv
module plane_store #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 256,
  parameter int NRD   = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [PIX_W-1:0]     wr_data,
  input  logic [NRD*AW-1:0]    rd_addr,
  output logic [NRD*PIX_W-1:0] rd_data
);
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g*PIX_W +: PIX_W] = mem[rd_addr[g*AW +: AW]];
  end
endmodule

// File: rtl/quad_average.sv
module quad_average #(
  parameter int PIX_W = 8,
  localparam int SW   = PIX_W + 2
) (
  input  logic [4*PIX_W-1:0] taps,
  output logic [PIX_W-1:0]   avg
);
  logic [SW-1:0] sum;

  always_comb begin
    sum = SW'(2);
    for (int t = 0; t < 4; t++) sum = sum + SW'(taps[t*PIX_W +: PIX_W]);
  end

  assign avg = sum[SW-1:2];
endmodule

// File: rtl/pool_ctrl.sv
module pool_ctrl
  import cds_pkg::*;
#(
  parameter int SIDE  = 16,
  localparam int HALF = SIDE / 2,
  localparam int AW   = $clog2(SIDE * SIDE),
  localparam int HW   = $clog2(HALF),
  localparam int OW   = 2 * HW,
  localparam int LASTIN  = SIDE * SIDE - 1,
  localparam int LASTOUT = HALF * HALF - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_comp,
  input  logic               out_ready,
  output logic               in_ready,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr,
  output logic [TAPS*AW-1:0] rd_addr,
  output logic               out_valid,
  output logic               out_sob,
  output logic               out_eob,
  output logic               out_comp
);
  phase_t        phase;
  logic [AW-1:0] fill_cnt;
  logic [OW-1:0] out_idx;
  logic          tag;
  logic          in_fire, out_fire;
  logic [AW-1:0] base;

  assign in_fire  = in_valid && (phase == PH_FILL);
  assign out_fire = out_ready && (phase == PH_DRAIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_FILL;
      fill_cnt <= '0;
      out_idx  <= '0;
      tag      <= 1'b0;
    end else begin
      if (in_fire) begin
        if (fill_cnt == '0) tag <= in_comp;
        if (fill_cnt == AW'(LASTIN)) begin
          fill_cnt <= '0;
          phase    <= PH_DRAIN;
        end else begin
          fill_cnt <= fill_cnt + 1'b1;
        end
      end
      if (out_fire) begin
        if (out_idx == OW'(LASTOUT)) begin
          out_idx <= '0;
          phase   <= PH_FILL;
        end else begin
          out_idx <= out_idx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    base = AW'(2 * SIDE * int'(out_idx[OW-1:HW]) + 2 * int'(out_idx[HW-1:0]));
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    localparam int OFF = (g / 2) * SIDE + (g % 2);
    assign rd_addr[g*AW +: AW] = base + AW'(OFF);
  end

  assign in_ready  = (phase == PH_FILL);
  assign wr_en     = in_fire;
  assign wr_addr   = fill_cnt;
  assign out_valid = (phase == PH_DRAIN);
  assign out_sob   = out_valid && (out_idx == '0);
  assign out_eob   = out_valid && (out_idx == OW'(LASTOUT));
  assign out_comp  = tag;

  // R4
  fill_to_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && (fill_cnt == AW'(LASTIN)) |=> out_valid && out_sob && !in_ready);

  // R3
  reopen_after_eob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_eob |=> in_ready && !out_valid);

  // R8
  sob_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_sob |=> !out_sob);

  // R9
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid || $stable(out_comp));
endmodule

// File: rtl/chroma_pool2x2.sv
module chroma_pool2x2
  import cds_pkg::*;
#(
  parameter int SIDE  = 16,
  parameter int PIX_W = 8,
  localparam int DEPTH = SIDE * SIDE,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_comp,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_comp,
  output logic             out_sob,
  output logic             out_eob
);
  logic                    wr_en;
  logic [AW-1:0]           wr_addr;
  logic [TAPS*AW-1:0]      rd_addr;
  logic [TAPS*PIX_W-1:0]   rd_data;

  pool_ctrl #(.SIDE(SIDE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_comp(in_comp),
    .out_ready(out_ready), .in_ready(in_ready), .wr_en(wr_en),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .out_valid(out_valid),
    .out_sob(out_sob), .out_eob(out_eob), .out_comp(out_comp)
  );

  plane_store #(.PIX_W(PIX_W), .DEPTH(DEPTH), .NRD(TAPS)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  quad_average #(.PIX_W(PIX_W)) u_avg (
    .taps(rd_data), .avg(out_data)
  );

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
      $stable(out_sob) && $stable(out_eob));

  // R3
  closed_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !wr_en);
endmodule

// File: tb/chroma_pool2x2_test.sv
module chroma_pool2x2_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'd0;
  logic       in_comp = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_comp, out_sob, out_eob;

  int nchk = 0, nbad = 0;
  int rmode = 0;
  bit finished = 0;
  bit gap_en = 0;

  bit m_drain = 0;
  int m_cnt = 0, m_k = 0, blocks_out = 0;
  bit m_tag = 0;
  int ref_pix [256];

  always #5 clk = ~clk;

  chroma_pool2x2 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_comp(in_comp), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_comp(out_comp),
    .out_sob(out_sob), .out_eob(out_eob)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d (k=%0d)", req, act, exp, m_k);
    end
  endtask

  function automatic int exp_avg(int k);
    int b;
    b = 2 * (k / 8) * 16 + 2 * (k % 8);
    return (ref_pix[b] + ref_pix[b+1] + ref_pix[b+16] + ref_pix[b+17] + 2) >> 2;
  endfunction

  // output-side ready patterns
  always @(negedge clk) begin
    #1;
    case (rmode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom % 2) == 0;
      default: out_ready = ($urandom % 8) == 0;
    endcase
  end

  // cycle-by-cycle reference model
  always @(negedge clk) begin
    bit fi, fo;
    #3;
    if (!rst_n) begin
      m_drain = 0; m_cnt = 0; m_k = 0; m_tag = 0;
    end else if (!finished) begin
      chk(in_ready == !m_drain, "R3 in_ready", int'(in_ready), int'(!m_drain));
      chk(out_valid == m_drain, "R4 out_valid", int'(out_valid), int'(m_drain));
      if (m_drain) begin
        chk(int'(out_data) == exp_avg(m_k), "R5/R6 out_data", int'(out_data), exp_avg(m_k));
        chk(out_sob == (m_k == 0), "R8 out_sob", int'(out_sob), int'(m_k == 0));
        chk(out_eob == (m_k == 63), "R8 out_eob", int'(out_eob), int'(m_k == 63));
        chk(out_comp == m_tag, "R9 out_comp", int'(out_comp), int'(m_tag));
      end else begin
        chk(!out_sob && !out_eob, "R8 flags idle", int'({out_sob, out_eob}), 0);
      end
      fi = in_valid && !m_drain;
      fo = out_ready && m_drain;
      if (fi) begin
        if (m_cnt == 0) m_tag = in_comp;
        ref_pix[m_cnt] = int'(in_data);
        m_cnt++;
        if (m_cnt == 256) begin m_cnt = 0; m_drain = 1; end
      end else if (fo) begin
        m_k++;
        if (m_k == 64) begin m_k = 0; m_drain = 0; blocks_out++; end
      end
    end
  end

  function automatic logic [7:0] pix(int p, int n);
    case (p)
      0: return 8'(n);
      1: return 8'd255;
      2: return 8'd0;
      3: return 8'(100 + (n % 2));
      default: return 8'($urandom);
    endcase
  endfunction

  // R2 raster feed; R3 garbage offered while closed; R9 tag toggling on plane 3
  task automatic send_plane(int p, bit comp);
    for (int n = 0; n < 256; n++) begin
      bit sent = 0;
      while (!sent) begin
        @(negedge clk);
        #1;
        if (!in_ready) begin
          in_valid = 1'b1;
          in_data  = 8'($urandom);
          in_comp  = ~comp;
        end else if (gap_en && ($urandom % 5) == 0) begin
          in_valid = 1'b0;
        end else begin
          in_valid = 1'b1;
          in_data  = pix(p, n);
          in_comp  = (p == 3) ? (comp ^ bit'(n % 2)) : comp;
          sent = 1;
        end
      end
    end
  endtask

  task automatic summary;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog expired, blocks=%0d", blocks_out);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #4;
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    // R10: six planes back to back, alternating components
    for (int p = 0; p < 6; p++) begin
      case (p)
        0: rmode = 0;
        1: rmode = 1;
        2: rmode = 2;
        3: rmode = 1;
        4: rmode = 0;
        default: rmode = 2;
      endcase
      gap_en = (p % 2) == 1;
      send_plane(p, bit'(p % 2));
    end
    @(negedge clk);
    #1;
    in_valid = 1'b0;
    while (blocks_out < 6) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(blocks_out == 6, "R10 block count", blocks_out, 6);
    summary();
  end
endmodule